// File: doc/BRIEF.md
# Coalesced Translation Response Fan-out

This block sits on the return side of an address-translation coalescer. Requests that fall in the same virtual page and share an access mode are merged into a group upstream. Only the first request of the group is sent for translation. While the group waits, its members are recorded in a small outstanding table. Each record holds the virtual page, and for every member that member's page-offset bits and the requester port that expects its answer.

When the single translation result comes back, the block searches the table for the result's virtual page and latches the matching group. It then returns one response per member, one per cycle, in the order the members were recorded, under a valid/ready handshake. The first member receives the translated physical address unchanged. Every later member's physical address is rebuilt from the translated page base and that member's own offset. The page size used for this comes with the result, so mixed page sizes are handled. The uncacheable mark, the validity and the hit level of the translation are copied to every member. The table entry is freed at the clock edge that ends the accepting cycle. A result whose page has no live entry is dropped and raises a one-cycle error pulse.

Top module: `xlat_fanout`

## Requirements
- R1: After reset, `out_vld` and `miss_err` are 0, `rsp_rdy` is 1 and the table holds no live entry, so the first result presented is treated as a miss.
- R2: An install with `ins_new`=1 opens a group in slot `ins_slot` with page `ins_page` and one member. Each further install to that live slot with `ins_new`=0 appends one member. Appends beyond MAXMEM members are ignored.
- R3: A result accepted (`rsp_vld`&`rsp_rdy`) for a live page produces one output per member, starting in the cycle after acceptance, in install order. Each output holds stable while `out_rdy` is 0, advances on `out_vld`&`out_rdy`, and `out_last` is 1 only on the final member.
- R4: The first member's `out_paddr` equals `rsp_paddr` unchanged.
- R5: Every later member's `out_paddr` is (`rsp_paddr` & ~(S-1)) | (VA & (S-1)). Here S = 2^(MINSH + STEP*`rsp_size`), which gives shifts 4, 6, 8 and 10 for codes 0 to 3 by default, and VA = {`rsp_page`, member offset}.
- R6: `out_uncache`, `out_tvalid` and `out_level` equal the accepted result's `rsp_uncache`, `rsp_tvalid` and `rsp_level` for every member.
- R7: `out_port` equals the requester port recorded for that member.
- R8: The matched entry stops being live at the edge that ends the accepting cycle, so a later result for the same page is a miss, and the slot can be opened again.
- R9: A result accepted for a page with no live entry issues no output and sets `miss_err` to 1 for exactly the cycle after acceptance.
- R10: `rsp_rdy` is 0 while a group is being returned and 1 once the last member has handshaked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_vld | input | 1 | Install one member into the table |
| ins_new | input | 1 | 1: open a new group in the slot; 0: append to it |
| ins_slot | input | SLOTW | Table slot written |
| ins_page | input | VPW | Virtual page of the group (used when opening) |
| ins_low | input | MINSH | Member's virtual address bits below the smallest page |
| ins_port | input | PORTW | Requester port of the member |
| rsp_vld | input | 1 | Translation result present |
| rsp_rdy | output | 1 | Block idle and able to take a result |
| rsp_page | input | VPW | Virtual page of the result |
| rsp_paddr | input | PAW | Translated physical address of the first member |
| rsp_size | input | CODEW | Page size code |
| rsp_uncache | input | 1 | Translation marked uncacheable |
| rsp_tvalid | input | 1 | Translation valid flag |
| rsp_level | input | LVLW | Level where the translation hit |
| out_vld | output | 1 | Member response present |
| out_rdy | input | 1 | Return path accepts the member response |
| out_port | output | PORTW | Requester port to route the response to |
| out_paddr | output | PAW | Reconstructed physical address |
| out_uncache | output | 1 | Uncacheable mark |
| out_tvalid | output | 1 | Translation valid flag |
| out_level | output | LVLW | Hit level |
| out_last | output | 1 | Final member of the group |
| miss_err | output | 1 | Result dropped because no live entry matched |

## Verification
Every cycle, the assertions check the return handshake (outputs held under back-pressure, nothing after the last member), that no output follows a miss, that a matched entry is no longer live after its accepting edge, and that no two live entries share a page. Whether each member's address, flags and port carry the right values, that members come out in install order, and that appends beyond the group limit are ignored can only be shown by the bench. It sweeps every page-size code against every group size, with back-pressure and with two groups live at once.

// File: rtl/xlat_fanout_pkg.sv
// Shared definitions for the translation response fan-out.
// Assumes nothing beyond IEEE 1800-2017 packages.
package xlat_fanout_pkg;

    // Fan-out sequencer state: waiting for a result, or returning members.
    typedef enum logic {
        FO_IDLE = 1'b0,
        FO_SEND = 1'b1
    } fo_state_e;

endpackage

// File: rtl/fo_table.sv
// Outstanding group table.
// Holds NENT groups of up to MAXMEM members each, keyed by virtual page.
// Looks up a page combinationally and frees the matched entry on free_en.
// Assumes the installer never keeps two live entries for one page.
module fo_table #(
    parameter int NENT   = 4,
    parameter int MAXMEM = 4,
    parameter int VPW    = 16,
    parameter int LOWW   = 4,
    parameter int PORTW  = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              ins_vld,
    input  logic                              ins_new,
    input  logic [$clog2(NENT)-1:0]           ins_slot,
    input  logic [VPW-1:0]                    ins_page,
    input  logic [LOWW-1:0]                   ins_low,
    input  logic [PORTW-1:0]                  ins_port,
    input  logic [VPW-1:0]                    look_page,
    input  logic                              free_en,
    output logic                              hit,
    output logic [$clog2(NENT)-1:0]           hit_slot,
    output logic [$clog2(MAXMEM+1)-1:0]       hit_cnt,
    output logic [MAXMEM-1:0][LOWW-1:0]       hit_lows,
    output logic [MAXMEM-1:0][PORTW-1:0]      hit_ports
);
    localparam int SLOTW = $clog2(NENT);
    localparam int CNTW  = $clog2(MAXMEM + 1);
    localparam int IDXW  = (MAXMEM > 1) ? $clog2(MAXMEM) : 1;

    logic [NENT-1:0]        ent_vld;
    logic [VPW-1:0]         ent_page [NENT];
    logic [CNTW-1:0]        ent_cnt  [NENT];
    logic [LOWW-1:0]        mem_low  [NENT][MAXMEM];
    logic [PORTW-1:0]       mem_port [NENT][MAXMEM];
    logic [NENT-1:0]        match;
    logic                   app_ok;
    logic                   wr_mem;
    logic [IDXW-1:0]        wr_idx;

    // Per-entry page comparators.
    generate
        for (genvar e = 0; e < NENT; e++) begin : g_cmp
            assign match[e] = ent_vld[e] && (ent_page[e] == look_page);
        end
    endgenerate

    // Encode the matching slot.
    always_comb begin
        hit      = |match;
        hit_slot = '0;
        for (int e = 0; e < NENT; e++) begin
            if (match[e]) hit_slot = SLOTW'(e);
        end
    end

    // Read out the matched group's member records.
    always_comb begin
        hit_cnt = ent_cnt[hit_slot];
        for (int m = 0; m < MAXMEM; m++) begin
            hit_lows[m]  = mem_low[hit_slot][m];
            hit_ports[m] = mem_port[hit_slot][m];
        end
    end

    // Decide whether an install writes a member record and where.
    always_comb begin
        app_ok = ent_vld[ins_slot] && (ent_cnt[ins_slot] < CNTW'(MAXMEM));
        wr_mem = ins_vld && (ins_new || app_ok);
        wr_idx = ins_new ? '0 : IDXW'(ent_cnt[ins_slot]);
    end

    // Live flags and member counts; an install overrides a same-cycle free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld <= '0;
            for (int e = 0; e < NENT; e++) ent_cnt[e] <= '0;
        end else begin
            if (free_en) ent_vld[hit_slot] <= 1'b0;
            if (ins_vld && ins_new) begin
                ent_vld[ins_slot] <= 1'b1;
                ent_cnt[ins_slot] <= CNTW'(1);
            end else if (ins_vld && app_ok) begin
                ent_cnt[ins_slot] <= ent_cnt[ins_slot] + CNTW'(1);
            end
        end
    end

    // Page keys and member records (no reset needed, gated by live flags).
    always_ff @(posedge clk) begin
        if (ins_vld && ins_new) ent_page[ins_slot] <= ins_page;
        if (wr_mem) begin
            mem_low[ins_slot][wr_idx]  <= ins_low;
            mem_port[ins_slot][wr_idx] <= ins_port;
        end
    end

    AST_FREE_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (free_en && !(ins_vld && ins_new && ins_slot == hit_slot)) |=> !ent_vld[$past(hit_slot)]); // R8

    AST_UNIQUE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R2

endmodule

// File: rtl/fo_seq.sv
// Fan-out sequencer.
// Accepts one translation result while idle, latches the matched group and
// the result fields, then steps through the members one per handshake.
// A result with no matching entry is dropped and flagged for one cycle.
// Assumes hit_cnt is at least 1 whenever hit is set.
module fo_seq
    import xlat_fanout_pkg::*;
#(
    parameter int MAXMEM = 4,
    parameter int VPW    = 16,
    parameter int LOWW   = 4,
    parameter int PORTW  = 2,
    parameter int PAW    = 24,
    parameter int CODEW  = 2,
    parameter int LVLW   = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rsp_vld,
    output logic                              rsp_rdy,
    input  logic [VPW-1:0]                    rsp_page,
    input  logic [PAW-1:0]                    rsp_paddr,
    input  logic [CODEW-1:0]                  rsp_size,
    input  logic                              rsp_uncache,
    input  logic                              rsp_tvalid,
    input  logic [LVLW-1:0]                   rsp_level,
    input  logic                              hit,
    input  logic [$clog2(MAXMEM+1)-1:0]       hit_cnt,
    input  logic [MAXMEM-1:0][LOWW-1:0]       hit_lows,
    input  logic [MAXMEM-1:0][PORTW-1:0]      hit_ports,
    output logic                              free_en,
    input  logic                              out_rdy,
    output logic                              out_vld,
    output logic                              out_last,
    output logic                              cur_first,
    output logic [LOWW-1:0]                   cur_low,
    output logic [PORTW-1:0]                  cur_port,
    output logic [VPW-1:0]                    g_page,
    output logic [PAW-1:0]                    g_paddr,
    output logic [CODEW-1:0]                  g_size,
    output logic                              g_uncache,
    output logic                              g_tvalid,
    output logic [LVLW-1:0]                   g_level,
    output logic                              miss_err
);
    localparam int CNTW = $clog2(MAXMEM + 1);
    localparam int IDXW = (MAXMEM > 1) ? $clog2(MAXMEM) : 1;

    fo_state_e                      state;
    logic [CNTW-1:0]                g_cnt;
    logic [IDXW-1:0]                idx;
    logic [MAXMEM-1:0][LOWW-1:0]    g_lows;
    logic [MAXMEM-1:0][PORTW-1:0]   g_ports;
    logic                           accept;
    logic                           take;

    // Handshake terms for both sides.
    always_comb begin
        rsp_rdy  = (state == FO_IDLE);
        accept   = rsp_vld && rsp_rdy;
        free_en  = accept && hit;
        out_vld  = (state == FO_SEND);
        out_last = ((CNTW'(idx) + CNTW'(1)) == g_cnt);
        take     = out_vld && out_rdy;
    end

    // Current member selection.
    always_comb begin
        cur_first = (idx == '0);
        cur_low   = g_lows[idx];
        cur_port  = g_ports[idx];
    end

    // State, member index and miss pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= FO_IDLE;
            idx      <= '0;
            miss_err <= 1'b0;
        end else begin
            miss_err <= accept && !hit;
            if (free_en) begin
                state <= FO_SEND;
                idx   <= '0;
            end else if (take) begin
                if (out_last) state <= FO_IDLE;
                else          idx   <= idx + IDXW'(1);
            end
        end
    end

    // Capture the result fields and the group records on a hit.
    always_ff @(posedge clk) begin
        if (free_en) begin
            g_page    <= rsp_page;
            g_paddr   <= rsp_paddr;
            g_size    <= rsp_size;
            g_uncache <= rsp_uncache;
            g_tvalid  <= rsp_tvalid;
            g_level   <= rsp_level;
            g_cnt     <= hit_cnt;
            g_lows    <= hit_lows;
            g_ports   <= hit_ports;
        end
    end

    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_rdy) |=> (out_vld && $stable(cur_port) && $stable(cur_low) && $stable(out_last))); // R3

    AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_rdy && out_last) |=> !out_vld); // R3

    AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        miss_err |-> !out_vld); // R9

    AST_BLOCK_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !(out_rdy && out_last)) |=> !rsp_rdy); // R10

endmodule

// File: rtl/fo_addr.sv
// Physical address rebuild for one member.
// The first member passes the translated address through; later members
// take the page base of the translated address and their own offset under
// the page size selected by size_code.
// Assumes MINSH + STEP*(2^CODEW-1) does not exceed VPW+MINSH or PAW.
module fo_addr #(
    parameter int VPW   = 16,
    parameter int MINSH = 4,
    parameter int STEP  = 2,
    parameter int CODEW = 2,
    parameter int PAW   = 24
) (
    input  logic [VPW-1:0]   vpage,
    input  logic [MINSH-1:0] low,
    input  logic [PAW-1:0]   paddr,
    input  logic [CODEW-1:0] size_code,
    input  logic             first,
    output logic [PAW-1:0]   out_paddr
);
    localparam int VAW = VPW + MINSH;
    localparam int AW  = (PAW > VAW) ? PAW : VAW;

    logic [AW-1:0] va;
    logic [AW-1:0] mask;
    logic [AW-1:0] pa_w;
    logic [AW-1:0] built;
    int unsigned   shamt;

    // Merge the page base with the member offset.
    always_comb begin
        shamt     = MINSH + STEP * int'(size_code);
        mask      = (AW'(1) << shamt) - AW'(1);
        va        = AW'({vpage, low});
        pa_w      = AW'(paddr);
        built     = (pa_w & ~mask) | (va & mask);
        out_paddr = first ? paddr : PAW'(built);
    end

endmodule

// File: rtl/xlat_fanout.sv
// Coalesced translation response fan-out (top).
// Records merged requests per virtual page, and on a translation result
// returns one response per member with a rebuilt physical address, copied
// flags and its own requester port. Frees the entry at the accepting edge.
// Assumes at most one live entry per page and installs only to free slots
// when opening a group.
module xlat_fanout #(
    parameter int NENT   = 4,
    parameter int MAXMEM = 4,
    parameter int NPORT  = 4,
    parameter int VPW    = 16,
    parameter int MINSH  = 4,
    parameter int STEP   = 2,
    parameter int CODEW  = 2,
    parameter int PAW    = 24,
    parameter int LVLW   = 2,
    localparam int SLOTW = $clog2(NENT),
    localparam int PORTW = $clog2(NPORT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_vld,
    input  logic              ins_new,
    input  logic [SLOTW-1:0]  ins_slot,
    input  logic [VPW-1:0]    ins_page,
    input  logic [MINSH-1:0]  ins_low,
    input  logic [PORTW-1:0]  ins_port,
    input  logic              rsp_vld,
    output logic              rsp_rdy,
    input  logic [VPW-1:0]    rsp_page,
    input  logic [PAW-1:0]    rsp_paddr,
    input  logic [CODEW-1:0]  rsp_size,
    input  logic              rsp_uncache,
    input  logic              rsp_tvalid,
    input  logic [LVLW-1:0]   rsp_level,
    output logic              out_vld,
    input  logic              out_rdy,
    output logic [PORTW-1:0]  out_port,
    output logic [PAW-1:0]    out_paddr,
    output logic              out_uncache,
    output logic              out_tvalid,
    output logic [LVLW-1:0]   out_level,
    output logic              out_last,
    output logic              miss_err
);
    localparam int CNTW = $clog2(MAXMEM + 1);

    logic                           hit;
    logic [SLOTW-1:0]               hit_slot;
    logic [CNTW-1:0]                hit_cnt;
    logic [MAXMEM-1:0][MINSH-1:0]   hit_lows;
    logic [MAXMEM-1:0][PORTW-1:0]   hit_ports;
    logic                           free_en;
    logic                           cur_first;
    logic [MINSH-1:0]               cur_low;
    logic [VPW-1:0]                 g_page;
    logic [PAW-1:0]                 g_paddr;
    logic [CODEW-1:0]               g_size;

    fo_table #(
        .NENT(NENT), .MAXMEM(MAXMEM), .VPW(VPW), .LOWW(MINSH), .PORTW(PORTW)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .ins_vld(ins_vld), .ins_new(ins_new), .ins_slot(ins_slot),
        .ins_page(ins_page), .ins_low(ins_low), .ins_port(ins_port),
        .look_page(rsp_page), .free_en(free_en),
        .hit(hit), .hit_slot(hit_slot), .hit_cnt(hit_cnt),
        .hit_lows(hit_lows), .hit_ports(hit_ports)
    );

    fo_seq #(
        .MAXMEM(MAXMEM), .VPW(VPW), .LOWW(MINSH), .PORTW(PORTW),
        .PAW(PAW), .CODEW(CODEW), .LVLW(LVLW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .rsp_vld(rsp_vld), .rsp_rdy(rsp_rdy), .rsp_page(rsp_page),
        .rsp_paddr(rsp_paddr), .rsp_size(rsp_size), .rsp_uncache(rsp_uncache),
        .rsp_tvalid(rsp_tvalid), .rsp_level(rsp_level),
        .hit(hit), .hit_cnt(hit_cnt), .hit_lows(hit_lows), .hit_ports(hit_ports),
        .free_en(free_en), .out_rdy(out_rdy), .out_vld(out_vld),
        .out_last(out_last), .cur_first(cur_first), .cur_low(cur_low),
        .cur_port(out_port), .g_page(g_page), .g_paddr(g_paddr),
        .g_size(g_size), .g_uncache(out_uncache), .g_tvalid(out_tvalid),
        .g_level(out_level), .miss_err(miss_err)
    );

    fo_addr #(
        .VPW(VPW), .MINSH(MINSH), .STEP(STEP), .CODEW(CODEW), .PAW(PAW)
    ) u_addr (
        .vpage(g_page), .low(cur_low), .paddr(g_paddr),
        .size_code(g_size), .first(cur_first), .out_paddr(out_paddr)
    );

    AST_FIRST_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        free_en |=> (out_vld && out_paddr == $past(rsp_paddr))); // R4

endmodule

// File: tb/tb_xlat_fanout.sv
`timescale 1ns/100ps
module tb_xlat_fanout;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ins_vld, ins_new;
    logic [1:0]  ins_slot;
    logic [15:0] ins_page;
    logic [3:0]  ins_low;
    logic [1:0]  ins_port;
    logic        rsp_vld, rsp_rdy;
    logic [15:0] rsp_page;
    logic [23:0] rsp_paddr;
    logic [1:0]  rsp_size;
    logic        rsp_uncache, rsp_tvalid;
    logic [1:0]  rsp_level;
    logic        out_vld, out_rdy;
    logic [1:0]  out_port;
    logic [23:0] out_paddr;
    logic        out_uncache, out_tvalid;
    logic [1:0]  out_level;
    logic        out_last, miss_err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    xlat_fanout dut (
        .clk(clk), .rst_n(rst_n),
        .ins_vld(ins_vld), .ins_new(ins_new), .ins_slot(ins_slot),
        .ins_page(ins_page), .ins_low(ins_low), .ins_port(ins_port),
        .rsp_vld(rsp_vld), .rsp_rdy(rsp_rdy), .rsp_page(rsp_page),
        .rsp_paddr(rsp_paddr), .rsp_size(rsp_size), .rsp_uncache(rsp_uncache),
        .rsp_tvalid(rsp_tvalid), .rsp_level(rsp_level),
        .out_vld(out_vld), .out_rdy(out_rdy), .out_port(out_port),
        .out_paddr(out_paddr), .out_uncache(out_uncache),
        .out_tvalid(out_tvalid), .out_level(out_level),
        .out_last(out_last), .miss_err(miss_err)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int low_of(int seed, int m);
        return (seed * 5 + m * 7 + 3) & 15;
    endfunction

    function automatic int port_of(int seed, int m);
        return (seed + m * 3) & 3;
    endfunction

    function automatic longint exp_pa(int page, int low, longint pa, int code, int m);
        longint size;
        longint va;
        size = longint'(1) << (4 + 2 * code);
        va   = (longint'(page) << 4) | longint'(low);
        if (m == 0) return pa;
        return ((pa & ~(size - 1)) | (va & (size - 1))) & 64'hFF_FFFF;
    endfunction

    // Install nins members (R2): first opens the group, the rest append.
    task automatic install(int slot, int page, int seed, int nins);
        for (int m = 0; m < nins; m++) begin
            ins_vld  = 1'b1;
            ins_new  = (m == 0);
            ins_slot = 2'(slot);
            ins_page = 16'(page);
            ins_low  = 4'(low_of(seed, m));
            ins_port = 2'(port_of(seed, m));
            tick();
        end
        ins_vld = 1'b0;
        ins_new = 1'b0;
    endtask

    task automatic present(int page, longint pa, int code, bit unc, bit tv, int lvl);
        rsp_vld     = 1'b1;
        rsp_page    = 16'(page);
        rsp_paddr   = 24'(pa);
        rsp_size    = 2'(code);
        rsp_uncache = unc;
        rsp_tvalid  = tv;
        rsp_level   = 2'(lvl);
        tick();
        rsp_vld = 1'b0;
    endtask

    // Present a hit and collect nexp member responses with back-pressure.
    task automatic run_group(int page, int seed, int nexp, longint pa, int code,
                             bit unc, bit tv, int lvl);
        longint e;
        present(page, pa, code, unc, tv, lvl);
        for (int m = 0; m < nexp; m++) begin
            e = exp_pa(page, low_of(seed, m), pa, code, m);
            if (((m + seed) % 3) == 0) begin
                out_rdy = 1'b0;
                tick();
                chk(out_vld == 1'b1, "R3 hold valid", out_vld, 1);
                chk(out_paddr == 24'(e), "R3 hold paddr", out_paddr, e);
                out_rdy = 1'b1;
            end
            chk(out_vld == 1'b1, "R3 member valid", out_vld, 1);
            chk(rsp_rdy == 1'b0, "R10 busy", rsp_rdy, 0);
            if (m == 0) chk(out_paddr == 24'(e), "R4 first paddr", out_paddr, e);
            else        chk(out_paddr == 24'(e), "R5 member paddr", out_paddr, e);
            chk(out_port == 2'(port_of(seed, m)), "R7 port", out_port, port_of(seed, m));
            chk(out_uncache == unc && out_tvalid == tv && out_level == 2'(lvl), "R6 flags",
                {out_uncache, out_tvalid, out_level}, {unc, tv, 2'(lvl)});
            chk(out_last == (m == nexp - 1), "R3 last", out_last, (m == nexp - 1));
            tick();
        end
        chk(out_vld == 1'b0, "R3 done", out_vld, 0);
        chk(rsp_rdy == 1'b1, "R10 idle", rsp_rdy, 1);
    endtask

    task automatic run_miss(int page, string req);
        present(page, 24'h123456, 1, 1'b0, 1'b1, 1);
        chk(miss_err == 1'b1, req, miss_err, 1);
        chk(out_vld == 1'b0, "R9 no output", out_vld, 0);
        tick();
        chk(miss_err == 1'b0, "R9 pulse ends", miss_err, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; ins_vld = 0; ins_new = 0; ins_slot = 0; ins_page = 0;
        ins_low = 0; ins_port = 0; rsp_vld = 0; rsp_page = 0; rsp_paddr = 0;
        rsp_size = 0; rsp_uncache = 0; rsp_tvalid = 0; rsp_level = 0; out_rdy = 1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk(out_vld == 1'b0, "R1 out_vld", out_vld, 0);
        chk(rsp_rdy == 1'b1, "R1 rsp_rdy", rsp_rdy, 1);
        chk(miss_err == 1'b0, "R1 miss_err", miss_err, 0);
        run_miss(5, "R1 empty table miss");

        // Sweep every page-size code against every group size (R5, R6).
        for (int code = 0; code < 4; code++) begin
            for (int n = 1; n <= 4; n++) begin
                int page;
                int seed;
                longint pa;
                page = code * 37 + n * 11 + 1;
                seed = code * 4 + n;
                pa   = (code * 32'h1357 + n * 32'h2468 + 32'h5A5) & 32'hFF_FFFF;
                install((code + n) & 3, page, seed, n);
                run_group(page, seed, n, pa, code, bit'(n & 1), bit'(code != 2),
                          (code + n) & 3);
            end
        end

        // R2: six installs, only four members kept.
        install(0, 200, 9, 6);
        run_group(200, 9, 4, 24'hABCDEF, 3, 1'b1, 1'b1, 2);
        // R8: entry freed after its result.
        run_miss(200, "R8 freed entry misses");
        run_miss(777, "R9 unknown page");

        // Two live groups, answered in reverse order of install.
        install(1, 300, 2, 3);
        install(2, 301, 7, 2);
        run_group(301, 7, 2, 24'h0F0F0F, 1, 1'b0, 1'b0, 3);
        run_group(300, 2, 3, 24'h777777, 2, 1'b1, 1'b0, 0);
        run_miss(300, "R8 second freed entry misses");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule